// File: doc/BRIEF.md
# I2C Target Address Responder

This block is the target half of an I2C controller. While the local unit is not acting as bus master, it follows the bus and compares each address byte that comes after a START with a programmable 7-bit own address. It can also accept the all-zeros general call address. When an address is accepted, the block acknowledges it, records the direction and stretches SCL low. Software then moves the data one byte at a time. Each byte is released by a single transfer pulse, and the STOP that ends the transaction raises a flag.

The host side sees a set of sticky flags that it clears by writing ones. Three of them, address detected, general call and stop detected, can each raise an interrupt through their own enable. Bus inputs are raw pad levels. Both bus outputs are open-drain pull-down enables: a 1 pulls the line low.

Top module: `i2c_tgt_responder`

## Requirements
- R1: After reset, neither bus line is pulled low, every flag reads 0, `rx_data_o` reads 0 and `irq_o` reads 0.
- R2: When bits 7..1 of the first byte after a START equal a nonzero `own_addr_i`, the block pulls SDA low in the ninth bit. It sets flag bit 0 (address detected), and `rw_mode_o` takes bit 0 of that byte, where 1 means the remote master reads.
- R3: An address byte that matches neither the own address nor an accepted general call gets no acknowledge and sets no flag.
- R4: The byte 0x00 is acknowledged and sets flag bits 0 and 1 (general call) when `gc_dis_i` is 0. When `gc_dis_i` is 1 it is treated as R3.
- R5: After an acknowledged address, SCL is held low from the end of the ninth bit until `xfer_go_i` is pulsed. The release comes two clock cycles after the pulse.
- R6: In receive mode, after eight data bits the byte appears on `rx_data_o`, flag bit 4 (byte received) is set and SCL is held. The following pulse clears bit 4 and answers the byte with SDA low if `ack_nak_i` is 0, or leaves SDA released if it is 1.
- R7: In transmit mode, flag bit 3 (send buffer empty) is set while SCL is held, and a pulse sends `tx_data_i` MSB first. If the master acknowledges, the block holds SCL again and sets bit 3. If the master does not acknowledge, the block releases both lines.
- R8: A STOP seen after an acknowledged address sets flag bit 2 (stop detected). A STOP with no accepted address does not.
- R9: While transmitting, a 1 bit that reads back as 0 on SCL rising sets flag bit 5 (bus error), and the block releases SDA.
- R10: While `master_en_i` is 1, the block pulls no line low and ignores bus traffic.
- R11: A `xfer_go_i` pulse while SCL is not being held has no effect on the lines or the flags.
- R12: A repeated START followed by a non-matching address returns the block to idle, so the later STOP sets no flag.
- R13: `irq_o` is the OR of flag bits 0, 1 and 2, each ANDed with `irq_en_i` bits 0, 1 and 2. `flag_clr_i` clears flags by writing 1 to the bit positions of `flags_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL pad level |
| sda_i | input | 1 | SDA pad level |
| scl_oe_o | output | 1 | Pull SCL low (clock hold) |
| sda_oe_o | output | 1 | Pull SDA low |
| master_en_i | input | 1 | Local master owns SCL; responder inactive |
| own_addr_i | input | 7 | Own 7-bit address |
| gc_dis_i | input | 1 | Reject general call |
| ack_nak_i | input | 1 | Answer for received byte: 0 ACK, 1 NAK |
| xfer_go_i | input | 1 | Transfer-byte pulse releasing a hold |
| tx_data_i | input | 8 | Byte to send |
| rx_data_o | output | 8 | Last received byte |
| rw_mode_o | output | 1 | Direction of the accepted address |
| flag_clr_i | input | 6 | Write-one-to-clear mask for flags |
| irq_en_i | input | 3 | Interrupt enables: address, general call, stop |
| flags_o | output | 6 | Sticky flags: addr, gcall, stop, tx empty, rx full, bus error |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters, an 8-bit byte with a two-flop synchroniser, and acts as a bus master whose quarter bit period is eight clocks. The synchroniser and edge stage add three cycles of latency, which fits well inside each SCL phase. As a result, every clock hold, ACK slot and flag update can be seen at the ports before the master's next edge. The master model waits whenever SCL is stretched, so releases caused by the transfer pulse can be checked through the bus itself.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;
  localparam int FLAG_W  = 6;
  localparam int IRQ_W   = 3;
  localparam int F_ADDR  = 0;
  localparam int F_GCALL = 1;
  localparam int F_STOP  = 2;
  localparam int F_TXE   = 3;
  localparam int F_RXF   = 4;
  localparam int F_BERR  = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_HOLD, ST_RXB, ST_RACK, ST_TXB, ST_TACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
`timescale 1ns/1ps
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int L = STAGES + 1;

  logic [L-1:0] scl_q, sda_q;
  logic s_scl, p_scl, s_sda, p_sda;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[L-2:0], scl_i};
      sda_q <= {sda_q[L-2:0], sda_i};
    end
  end

  assign s_scl = scl_q[L-2];
  assign p_scl = scl_q[L-1];
  assign s_sda = sda_q[L-2];
  assign p_sda = sda_q[L-1];

  assign sda_o      = s_sda;
  assign scl_rise_o = s_scl & ~p_scl;
  assign scl_fall_o = ~s_scl & p_scl;
  // SDA moving while SCL stays high
  assign start_o    = s_scl & p_scl & p_sda & ~s_sda;
  assign stop_o     = s_scl & p_scl & ~p_sda & s_sda;
endmodule

// File: rtl/i2c_tgt_flags.sv
`timescale 1ns/1ps
module i2c_tgt_flags #(
  parameter int NF = 6,
  parameter int NI = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  input  logic [NI-1:0] irq_en_i,
  output logic [NF-1:0] flags_o,
  output logic          irq_o
);
  logic [NF-1:0] flags_q;
  logic [NI-1:0] irq_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_i) | set_i;  // set wins
  end

  for (genvar g = 0; g < NI; g++) begin : g_irq
    assign irq_vec[g] = flags_q[g] & irq_en_i[g];
  end

  assign flags_o = flags_q;
  assign irq_o   = |irq_vec;
endmodule

// File: rtl/i2c_tgt_responder.sv
`timescale 1ns/1ps
module i2c_tgt_responder
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic              master_en_i,
  input  logic [DATA_W-2:0] own_addr_i,
  input  logic              gc_dis_i,
  input  logic              ack_nak_i,
  input  logic              xfer_go_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rw_mode_o,
  input  logic [FLAG_W-1:0] flag_clr_i,
  input  logic [IRQ_W-1:0]  irq_en_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  tgt_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d, rx_q, rx_d;
  logic rw_q, rw_d, adr_q, adr_d, rel_q, rel_d, rxack_q, rxack_d;
  logic mack_q, mack_d, scl_oe_q, scl_oe_d, sda_oe_q, sda_oe_d;
  logic [FLAG_W-1:0] flag_set, flag_clr;
  logic go_ok, own_hit, gc_hit;

  assign own_hit = (sh_q[DATA_W-1:1] == own_addr_i) && (own_addr_i != '0);
  assign gc_hit  = (sh_q == '0) && !gc_dis_i;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    rx_d     = rx_q;
    rw_d     = rw_q;
    adr_d    = adr_q;
    rel_d    = rel_q;
    rxack_d  = rxack_q;
    mack_d   = mack_q;
    scl_oe_d = scl_oe_q;
    sda_oe_d = sda_oe_q;
    flag_set = '0;
    go_ok    = 1'b0;
    if (master_en_i) begin
      state_d  = ST_IDLE;
      scl_oe_d = 1'b0;
      sda_oe_d = 1'b0;
      rel_d    = 1'b0;
      adr_d    = 1'b0;
    end else if (stop_det) begin
      if (adr_q) flag_set[F_STOP] = 1'b1;
      state_d  = ST_IDLE;
      adr_d    = 1'b0;
      scl_oe_d = 1'b0;
      sda_oe_d = 1'b0;
      rel_d    = 1'b0;
    end else if (start_det) begin
      state_d  = ST_ADDR;
      cnt_d    = '0;
      adr_d    = 1'b0;
      rxack_d  = 1'b0;
      scl_oe_d = 1'b0;
      sda_oe_d = 1'b0;
      rel_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[DATA_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST) begin
            if (own_hit || gc_hit) begin
              sda_oe_d         = 1'b1;
              rw_d             = sh_q[0];
              adr_d            = 1'b1;
              flag_set[F_ADDR] = 1'b1;
              flag_set[F_GCALL] = gc_hit;
              state_d          = ST_AACK;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          sda_oe_d        = 1'b0;
          scl_oe_d        = 1'b1;
          cnt_d           = '0;
          flag_set[F_TXE] = rw_q;
          state_d         = ST_HOLD;
        end
        ST_HOLD: begin
          if (rel_q) begin
            // SDA set one cycle before SCL is let go
            scl_oe_d = 1'b0;
            rel_d    = 1'b0;
            cnt_d    = '0;
            state_d  = rw_q ? ST_TXB : (rxack_q ? ST_RACK : ST_RXB);
          end else if (xfer_go_i) begin
            go_ok = 1'b1;
            rel_d = 1'b1;
            if (rw_q) begin
              sh_d     = tx_data_i;
              sda_oe_d = ~tx_data_i[DATA_W-1];
            end else if (rxack_q) begin
              sda_oe_d = ~ack_nak_i;
            end
          end
        end
        ST_RXB: begin
          if (scl_rise) begin
            sh_d  = {sh_q[DATA_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST) begin
            rx_d            = sh_q;
            flag_set[F_RXF] = 1'b1;
            scl_oe_d        = 1'b1;
            rxack_d         = 1'b1;
            state_d         = ST_HOLD;
          end
        end
        ST_RACK: if (scl_fall) begin
          sda_oe_d = 1'b0;
          rxack_d  = 1'b0;
          cnt_d    = '0;
          state_d  = ST_RXB;
        end
        ST_TXB: begin
          if (scl_rise) begin
            if (!sda_oe_q && !sda_s) begin
              flag_set[F_BERR] = 1'b1;
              sda_oe_d         = 1'b0;
              state_d          = ST_IDLE;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else if (scl_fall) begin
            if (cnt_q == LAST) begin
              sda_oe_d = 1'b0;
              state_d  = ST_TACK;
            end else begin
              sh_d     = {sh_q[DATA_W-2:0], 1'b0};
              sda_oe_d = ~sh_q[DATA_W-2];
            end
          end
        end
        ST_TACK: begin
          if (scl_rise) begin
            mack_d = sda_s;
          end else if (scl_fall) begin
            if (!mack_q) begin
              scl_oe_d        = 1'b1;
              flag_set[F_TXE] = 1'b1;
              state_d         = ST_HOLD;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    flag_clr = flag_clr_i;
    if (go_ok) begin
      flag_clr[F_TXE] = 1'b1;
      flag_clr[F_RXF] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      rx_q     <= '0;
      rw_q     <= 1'b0;
      adr_q    <= 1'b0;
      rel_q    <= 1'b0;
      rxack_q  <= 1'b0;
      mack_q   <= 1'b1;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      rx_q     <= rx_d;
      rw_q     <= rw_d;
      adr_q    <= adr_d;
      rel_q    <= rel_d;
      rxack_q  <= rxack_d;
      mack_q   <= mack_d;
      scl_oe_q <= scl_oe_d;
      sda_oe_q <= sda_oe_d;
    end
  end

  i2c_tgt_flags #(.NF(FLAG_W), .NI(IRQ_W)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (flag_set),
    .clr_i    (flag_clr),
    .irq_en_i (irq_en_i),
    .flags_o  (flags_o),
    .irq_o    (irq_o)
  );

  assign scl_oe_o  = scl_oe_q;
  assign sda_oe_o  = sda_oe_q;
  assign rx_data_o = rx_q;
  assign rw_mode_o = rw_q;
endmodule

// File: rtl/i2c_tgt_checker.sv
`timescale 1ns/1ps
module i2c_tgt_checker
  import i2c_tgt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              master_en_i,
  input logic              xfer_go_i,
  input logic              gc_dis_i,
  input logic              scl_oe_o,
  input logic              sda_oe_o,
  input logic [FLAG_W-1:0] flags_o
);
  assert_addr_ack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[F_ADDR]) |-> sda_oe_o);

  assert_gcall_enabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[F_GCALL]) |-> !$past(gc_dis_i));

  assert_hold_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_oe_o) |-> ($past(xfer_go_i, 2) || $past(master_en_i)));

  assert_rx_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[F_RXF]) |-> scl_oe_o);

  assert_tx_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[F_TXE]) |-> scl_oe_o);

  assert_berr_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[F_BERR]) |-> !sda_oe_o);

  assert_master_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_en_i |=> (!scl_oe_o && !sda_oe_o));
endmodule

bind i2c_tgt_responder i2c_tgt_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .master_en_i (master_en_i),
  .xfer_go_i   (xfer_go_i),
  .gc_dis_i    (gc_dis_i),
  .scl_oe_o    (scl_oe_o),
  .sda_oe_o    (sda_oe_o),
  .flags_o     (flags_o)
);

// File: tb/i2c_tgt_responder_tb_top.sv
`timescale 1ns/1ps
module i2c_tgt_responder_tb_top;
  localparam int QTR = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe, scl_bus, sda_bus;
  logic master_en = 1'b0, gc_dis = 1'b0, ack_nak = 1'b0, xfer_go = 1'b0;
  logic [6:0] own_addr = 7'h2A;
  logic [7:0] tx_data = 8'h00, rx_data;
  logic rw_mode, irq;
  logic [5:0] flag_clr = '0, flags;
  logic [2:0] irq_en = '0;

  assign scl_bus = scl_m & ~scl_oe;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_tgt_responder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .master_en_i(master_en),
    .own_addr_i(own_addr), .gc_dis_i(gc_dis), .ack_nak_i(ack_nak),
    .xfer_go_i(xfer_go), .tx_data_i(tx_data), .rx_data_o(rx_data),
    .rw_mode_o(rw_mode), .flag_clr_i(flag_clr), .irq_en_i(irq_en),
    .flags_o(flags), .irq_o(irq)
  );

  int checks = 0, errs = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qwait(); repeat (QTR) @(negedge clk); endtask
  task automatic wait_scl_high(); do @(negedge clk); while (!scl_bus); endtask

  task automatic m_start();
    sda_m = 1'b1; qwait(); scl_m = 1'b1; wait_scl_high(); qwait();
    sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
  endtask
  task automatic m_stop();
    sda_m = 1'b0; qwait(); scl_m = 1'b1; wait_scl_high(); qwait();
    sda_m = 1'b1; qwait(); qwait();
  endtask
  task automatic m_bit(input logic b, output logic s);
    sda_m = b; qwait(); scl_m = 1'b1; wait_scl_high(); qwait();
    s = sda_bus; qwait(); scl_m = 1'b0; qwait();
  endtask
  task automatic m_wbyte(input logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) m_bit(d[i], s);
  endtask
  task automatic m_rbyte(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) m_bit(1'b1, d[i]);
  endtask
  task automatic go();
    @(negedge clk) xfer_go = 1'b1; @(negedge clk) xfer_go = 1'b0;
  endtask
  task automatic clr_all();
    @(negedge clk) flag_clr = '1; @(negedge clk) flag_clr = '0;
  endtask

  typedef struct packed {
    logic [6:0] own; logic gcd; logic [7:0] abyte; logic ack; logic gc;
  } vec_t;
  localparam vec_t VECS [6] = '{
    '{7'h2A, 1'b0, 8'h54, 1'b1, 1'b0},
    '{7'h2A, 1'b0, 8'h56, 1'b0, 1'b0},
    '{7'h11, 1'b0, 8'h22, 1'b1, 1'b0},
    '{7'h2A, 1'b0, 8'h00, 1'b1, 1'b1},
    '{7'h2A, 1'b1, 8'h00, 1'b0, 1'b0},
    '{7'h7F, 1'b0, 8'hFE, 1'b1, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic s;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 flags", flags, 0);
    chk("R1 rx_data", rx_data, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // address table
    for (int i = 0; i < 6; i++) begin
      own_addr = VECS[i].own; gc_dis = VECS[i].gcd;
      clr_all();
      m_start(); m_wbyte(VECS[i].abyte); m_bit(1'b1, s);
      chk("R2/R3 ack slot", s, !VECS[i].ack);
      chk("R2 addr flag", flags[0], VECS[i].ack);
      chk("R4 gcall flag", flags[1], VECS[i].gc);
      if (VECS[i].ack) begin
        chk("R5 scl held", scl_oe, 1);
        go();
      end
      m_stop();
      chk("R8 stop flag", flags[2], VECS[i].ack);
    end
    own_addr = 7'h2A; gc_dis = 1'b0;

    // R11: transfer pulse in idle
    clr_all(); go(); repeat (6) @(negedge clk);
    chk("R11 no scl drive", scl_oe, 0);
    chk("R11 no sda drive", sda_oe, 0);
    chk("R11 flags", flags, 0);

    // receive path
    m_start(); m_wbyte(8'h54); m_bit(1'b1, s);
    chk("R2 rw_mode write", rw_mode, 0);
    chk("R5 held after addr", scl_bus, 0);
    go();
    m_wbyte(8'hA5);
    chk("R6 rx_full", flags[4], 1);
    chk("R6 rx_data", rx_data, 8'hA5);
    chk("R6 scl held", scl_oe, 1);
    ack_nak = 1'b0; go();
    chk("R6 rx_full cleared", flags[4], 0);
    m_bit(1'b1, s);
    chk("R6 ack sent", s, 0);
    m_wbyte(8'h3C);
    chk("R6 rx_data 2", rx_data, 8'h3C);
    ack_nak = 1'b1; go();
    m_bit(1'b1, s);
    chk("R6 nak sent", s, 1);
    m_stop(); ack_nak = 1'b0;
    chk("R8 stop after rx", flags[2], 1);

    // transmit path
    clr_all();
    m_start(); m_wbyte(8'h55); m_bit(1'b1, s);
    chk("R2 ack read addr", s, 0);
    chk("R2 rw_mode read", rw_mode, 1);
    chk("R7 tx_empty", flags[3], 1);
    tx_data = 8'hC3; go();
    m_rbyte(d);
    chk("R7 byte1", d, 8'hC3);
    m_bit(1'b0, s);
    chk("R7 tx_empty again", flags[3], 1);
    chk("R7 held after ack", scl_oe, 1);
    tx_data = 8'h5A; go();
    m_rbyte(d);
    chk("R7 byte2", d, 8'h5A);
    m_bit(1'b1, s);
    chk("R7 released after nak scl", scl_oe, 0);
    chk("R7 released after nak sda", sda_oe, 0);
    m_stop();
    chk("R8 stop after tx", flags[2], 1);
    chk("R13 irq masked", irq, 0);

    // bus error
    clr_all();
    m_start(); m_wbyte(8'h55); m_bit(1'b1, s);
    tx_data = 8'hFF; go();
    m_bit(1'b0, s);
    chk("R9 bus error flag", flags[5], 1);
    chk("R9 sda released", sda_oe, 0);
    m_stop();
    irq_en = 3'b100; @(negedge clk);
    chk("R13 irq on stop", irq, 1);
    clr_all();
    chk("R13 irq after clear", irq, 0);
    irq_en = '0;

    // master enable
    master_en = 1'b1;
    m_start(); m_wbyte(8'h54); m_bit(1'b1, s);
    chk("R10 no ack", s, 1);
    chk("R10 no flags", flags, 0);
    m_stop();
    chk("R10 no stop flag", flags, 0);
    master_en = 1'b0;

    // repeated start, non-matching
    clr_all();
    m_start(); m_wbyte(8'h54); m_bit(1'b1, s); go();
    m_start(); m_wbyte(8'h56); m_bit(1'b1, s);
    chk("R12 nak after rs", s, 1);
    chk("R12 no hold", scl_oe, 0);
    m_stop();
    chk("R12 no stop flag", flags[2], 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule